// File: doc/BRIEF.md
# Multicast Route Direction Computer

This block sits in the route-compute stage of a mesh router. It takes the destinations of one multicast packet and chooses an output direction for each one. The result is a five-bit mask of the directions the packet must leave on, plus the set of destinations carried on each of those directions. The rules try to keep destinations together, so the packet is copied as few times as possible and as late as possible along its path.

Directions are numbered as follows: East is 0 (x grows), West is 1 (x shrinks), North is 2 (y grows), South is 3 (y shrinks) and Local is 4. The per-direction destination set is flattened so that bit `d*NDEST+i` means destination slot `i` leaves on direction `d`.

Each destination is placed by the first rule that applies:

- A destination at the current node goes to Local.
- A destination on the same row or column goes along that axis.
- A destination in a quadrant first tries to join a direction that the axis destinations already use.
- Leftover quadrant destinations that can share a direction are merged onto that direction.
- Any destination still unplaced follows the direction that an adaptive unicast route toward the corner of the observation window would take. That choice arrives as one hint bit per quadrant.

The result is registered. It is valid in the cycle after a start pulse and is held until the next start.

Top module: `mcr_route_top`

## Requirements
- R1: `out_valid` is high for exactly the one cycle after a cycle with `start` high, and low otherwise. `dir_mask` and `dir_dests` change only in the cycle after `start` and hold their value in every other cycle, even if the inputs change.
- R2: While `rst` is high, and after it until the first start, `out_valid`, `dir_mask` and `dir_dests` are all zero.
- R3: A valid destination whose coordinates equal (`cur_x`, `cur_y`) is placed on Local (direction 4) and on no other direction.
- R4: A valid destination that differs from the current node in only one coordinate is placed on that axis direction: East or West when only x differs, North or South when only y differs.
- R5: A quadrant destination (both coordinates differ) has a horizontal candidate (E/W) and a vertical candidate (N/S). It joins its horizontal candidate if an R4 destination uses it. Otherwise it joins its vertical candidate if an R4 destination uses that.
- R6: Among the quadrant destinations left over after R5, each of the four directions E, W, N, S counts how many have it as a candidate. The direction with the highest count wins, with ties going to the first in the order E, W, N, S. If the winning count is at least 2, every leftover destination that has the winner as a candidate is placed on it.
- R7: A destination still unplaced after R6 uses `quad_hint[q]`, where q = 2*(dest_y < cur_y) + (dest_x < cur_x). A hint of 1 selects the horizontal candidate and 0 selects the vertical one.
- R8: Every valid destination appears on exactly one direction. Destinations whose `dest_valid` bit is 0 appear on none.
- R9: `dir_mask[d]` is 1 exactly when some destination is placed on direction d.
- R10: For arbitrary positions, valid bits and hints, the full output equals the rules R3 to R7 applied in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Compute request; inputs are sampled in this cycle |
| cur_x | input | CW | Current node x |
| cur_y | input | CW | Current node y |
| dest_valid | input | NDEST | Slot i holds a destination |
| dest_x | input | NDEST*CW | Destination x, slot i at bits i*CW |
| dest_y | input | NDEST*CW | Destination y, slot i at bits i*CW |
| quad_hint | input | 4 | Adaptive unicast choice per quadrant, 1 = horizontal |
| out_valid | output | 1 | Result valid pulse |
| dir_mask | output | 5 | Directions used (E,W,N,S,L = bits 0..4) |
| dir_dests | output | 5*NDEST | Destinations per direction, bit d*NDEST+i |

## Verification
Because the result is registered once per start, a wrong rule decision shows up as a wrong bit in `dir_dests` in the first cycle of `out_valid`. The error appears for that slot only, and usually together with a changed `dir_mask` bit. A stuck or leaking leftover set or a miscounted candidate total moves destinations between directions. It can also drop a destination or duplicate it, which the one-direction-per-destination property flags in that same valid cycle. Register faults appear as outputs that drift while no start is present, and the bench catches this in the cycle after each result.

// File: rtl/mcr_pkg.sv
package mcr_pkg;

    localparam int NDIR  = 5;
    localparam int DIR_E = 0;
    localparam int DIR_W = 1;
    localparam int DIR_N = 2;
    localparam int DIR_S = 3;
    localparam int DIR_L = 4;

    // Geometry of one destination relative to the current node
    typedef struct packed {
        logic       live;   // slot holds a destination
        logic       here;   // equals current node
        logic       axis;   // same row or same column
        logic [2:0] adir;   // axis direction when axis
        logic [2:0] hdir;   // horizontal candidate
        logic [2:0] vdir;   // vertical candidate
        logic [1:0] quad;   // {below, left}
    } geo_t;

    function automatic geo_t locate(input logic live, input logic xgt, input logic xlt,
                                    input logic ygt, input logic ylt);
        geo_t g;
        logic xeq;
        logic yeq;
        xeq    = !xgt && !xlt;
        yeq    = !ygt && !ylt;
        g.live = live;
        g.here = live && xeq && yeq;
        g.axis = live && !(xeq && yeq) && (xeq || yeq);
        g.hdir = xgt ? 3'(DIR_E) : 3'(DIR_W);
        g.vdir = ygt ? 3'(DIR_N) : 3'(DIR_S);
        g.adir = yeq ? g.hdir : g.vdir;
        g.quad = {ylt, xlt};
        return g;
    endfunction

endpackage

// File: rtl/mcr_classify.sv
module mcr_classify
    import mcr_pkg::*;
#(
    parameter int NDEST = 10,
    parameter int CW    = 4
) (
    input  logic [CW-1:0]          cur_x,
    input  logic [CW-1:0]          cur_y,
    input  logic [NDEST-1:0]       dest_valid,
    input  logic [NDEST*CW-1:0]    dest_x,
    input  logic [NDEST*CW-1:0]    dest_y,
    output geo_t [NDEST-1:0]       geo
);

    for (genvar i = 0; i < NDEST; i++) begin : g_slot
        logic [CW-1:0] px;
        logic [CW-1:0] py;
        assign px = dest_x[i*CW +: CW];
        assign py = dest_y[i*CW +: CW];
        assign geo[i] = locate(dest_valid[i], px > cur_x, px < cur_x,
                               py > cur_y, py < cur_y);
    end

endmodule

// File: rtl/mcr_assign.sv
module mcr_assign
    import mcr_pkg::*;
#(
    parameter int NDEST = 10
) (
    input  geo_t [NDEST-1:0]             geo,
    input  logic [3:0]                   quad_hint,
    output logic [NDIR-1:0][NDEST-1:0]   sel
);

    localparam int CNTW = $clog2(NDEST + 1);

    logic [3:0]            used;
    logic [NDEST-1:0]      rem;
    logic [3:0][CNTW-1:0]  cnt;
    logic [2:0]            best;
    logic                  grouped;

    always_comb begin
        sel     = '0;
        used    = '0;
        rem     = '0;
        cnt     = '0;
        best    = 3'(DIR_E);
        grouped = 1'b0;

        // local and axis destinations
        for (int i = 0; i < NDEST; i++) begin
            if (geo[i].here) begin
                sel[DIR_L][i] = 1'b1;
            end else if (geo[i].axis) begin
                sel[geo[i].adir][i] = 1'b1;
                used[geo[i].adir[1:0]] = 1'b1;
            end
        end

        // quadrant destinations join an axis direction already taken
        for (int i = 0; i < NDEST; i++) begin
            if (geo[i].live && !geo[i].here && !geo[i].axis) begin
                if (used[geo[i].hdir[1:0]])
                    sel[geo[i].hdir][i] = 1'b1;
                else if (used[geo[i].vdir[1:0]])
                    sel[geo[i].vdir][i] = 1'b1;
                else
                    rem[i] = 1'b1;
            end
        end

        // candidate totals among the leftovers
        for (int d = 0; d < 4; d++) begin
            for (int i = 0; i < NDEST; i++) begin
                if (rem[i] && (geo[i].hdir == 3'(d) || geo[i].vdir == 3'(d)))
                    cnt[d] = cnt[d] + CNTW'(1);
            end
        end
        for (int d = 1; d < 4; d++) begin
            if (cnt[d] > cnt[best[1:0]])
                best = 3'(d);
        end
        grouped = cnt[best[1:0]] >= CNTW'(2);

        // shared direction, then the adaptive corner route
        for (int i = 0; i < NDEST; i++) begin
            if (rem[i]) begin
                if (grouped && (geo[i].hdir == best || geo[i].vdir == best))
                    sel[best][i] = 1'b1;
                else if (quad_hint[geo[i].quad])
                    sel[geo[i].hdir][i] = 1'b1;
                else
                    sel[geo[i].vdir][i] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/mcr_route_top.sv
module mcr_route_top
    import mcr_pkg::*;
#(
    parameter int NDEST = 10,
    parameter int CW    = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    input  logic [CW-1:0]          cur_x,
    input  logic [CW-1:0]          cur_y,
    input  logic [NDEST-1:0]       dest_valid,
    input  logic [NDEST*CW-1:0]    dest_x,
    input  logic [NDEST*CW-1:0]    dest_y,
    input  logic [3:0]             quad_hint,
    output logic                   out_valid,
    output logic [NDIR-1:0]        dir_mask,
    output logic [NDIR*NDEST-1:0]  dir_dests
);

    geo_t [NDEST-1:0]            geo;
    logic [NDIR-1:0][NDEST-1:0]  sel;
    logic [NDIR-1:0]             mask_d;

    mcr_classify #(.NDEST(NDEST), .CW(CW)) u_classify (
        .cur_x      (cur_x),
        .cur_y      (cur_y),
        .dest_valid (dest_valid),
        .dest_x     (dest_x),
        .dest_y     (dest_y),
        .geo        (geo)
    );

    mcr_assign #(.NDEST(NDEST)) u_assign (
        .geo       (geo),
        .quad_hint (quad_hint),
        .sel       (sel)
    );

    for (genvar d = 0; d < NDIR; d++) begin : g_mask
        assign mask_d[d] = |sel[d];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            dir_mask  <= '0;
            dir_dests <= '0;
        end else begin
            out_valid <= start;
            if (start) begin
                dir_mask  <= mask_d;
                dir_dests <= sel;
            end
        end
    end

endmodule

// File: rtl/mcr_route_chk.sv
module mcr_route_chk #(
    parameter int NDEST = 10
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  start,
    input logic [NDEST-1:0]      dest_valid,
    input logic                  out_valid,
    input logic [4:0]            dir_mask,
    input logic [5*NDEST-1:0]    dir_dests
);

    logic [NDEST-1:0] valid_q;
    logic [4:0]       col [NDEST];

    always_ff @(posedge clk) begin
        if (rst)        valid_q <= '0;
        else if (start) valid_q <= dest_valid;
    end

    always_comb begin
        for (int i = 0; i < NDEST; i++)
            for (int d = 0; d < 5; d++)
                col[i][d] = dir_dests[d*NDEST + i];
    end

    AST_VALID_AFTER_START: assert property (@(posedge clk) disable iff (rst) start |=> out_valid); // R1
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst) !start |=> !out_valid); // R1
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst) !start |=> $stable(dir_dests)); // R1

    for (genvar d = 0; d < 5; d++) begin : g_m
        AST_MASK_MATCHES_SETS: assert property (@(posedge clk) disable iff (rst)
            out_valid |-> dir_mask[d] == |dir_dests[d*NDEST +: NDEST]); // R9
    end

    for (genvar i = 0; i < NDEST; i++) begin : g_c
        AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (rst)
            out_valid |-> $countones(col[i]) == (valid_q[i] ? 1 : 0)); // R8
    end

endmodule

bind mcr_route_top mcr_route_chk #(.NDEST(NDEST)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .dest_valid (dest_valid),
    .out_valid  (out_valid),
    .dir_mask   (dir_mask),
    .dir_dests  (dir_dests)
);

// File: tb/sim_mcr_route_top.sv
module sim_mcr_route_top;

    localparam int N  = 10;
    localparam int CW = 3;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            start = 1'b0;
    logic [CW-1:0]   cur_x = '0;
    logic [CW-1:0]   cur_y = '0;
    logic [N-1:0]    dest_valid = '0;
    logic [N*CW-1:0] dest_x = '0;
    logic [N*CW-1:0] dest_y = '0;
    logic [3:0]      quad_hint = '0;
    logic            out_valid;
    logic [4:0]      dir_mask;
    logic [5*N-1:0]  dir_dests;

    int nchk = 0;
    int nbad = 0;
    bit done = 0;

    int tx [N];
    int ty [N];
    int cx, cy;

    always #4 clk = ~clk;

    mcr_route_top #(.NDEST(N), .CW(CW)) u0 (
        .clk(clk), .rst(rst), .start(start), .cur_x(cur_x), .cur_y(cur_y),
        .dest_valid(dest_valid), .dest_x(dest_x), .dest_y(dest_y),
        .quad_hint(quad_hint), .out_valid(out_valid), .dir_mask(dir_mask),
        .dir_dests(dir_dests)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int hcand(int i);
        return (tx[i] > cx) ? 0 : 1;
    endfunction

    function automatic int vcand(int i);
        return (ty[i] > cy) ? 2 : 3;
    endfunction

    // Rules applied in order, from the requirement text
    function automatic logic [5*N-1:0] model(logic [N-1:0] v, logic [3:0] h);
        int grp [N];
        bit taken [4];
        int tally [4];
        int win;
        logic [5*N-1:0] r;
        r = '0;
        for (int d = 0; d < 4; d++) begin taken[d] = 0; tally[d] = 0; end
        for (int i = 0; i < N; i++) begin
            if (!v[i])                           grp[i] = -2;
            else if (tx[i] == cx && ty[i] == cy) grp[i] = 4;
            else if (ty[i] == cy)                grp[i] = hcand(i);
            else if (tx[i] == cx)                grp[i] = vcand(i);
            else                                 grp[i] = -1;
            if (grp[i] >= 0 && grp[i] < 4) taken[grp[i]] = 1;
        end
        for (int i = 0; i < N; i++)
            if (grp[i] == -1) begin
                if (taken[hcand(i)])      grp[i] = hcand(i);
                else if (taken[vcand(i)]) grp[i] = vcand(i);
            end
        for (int i = 0; i < N; i++)
            if (grp[i] == -1) begin
                tally[hcand(i)]++;
                tally[vcand(i)]++;
            end
        win = 0;
        for (int d = 1; d < 4; d++) if (tally[d] > tally[win]) win = d;
        for (int i = 0; i < N; i++)
            if (grp[i] == -1) begin
                if (tally[win] >= 2 && (hcand(i) == win || vcand(i) == win))
                    grp[i] = win;
                else begin
                    int q;
                    q = ((ty[i] < cy) ? 2 : 0) + ((tx[i] < cx) ? 1 : 0);
                    grp[i] = h[q] ? hcand(i) : vcand(i);
                end
            end
        for (int i = 0; i < N; i++)
            if (grp[i] >= 0) r[grp[i]*N + i] = 1'b1;
        return r;
    endfunction

    task automatic run(input logic [N-1:0] v, input logic [3:0] h, input string tag);
        logic [5*N-1:0] exp;
        logic [4:0] em;
        logic [5*N-1:0] held;
        @(negedge clk);
        cur_x = CW'(cx);
        cur_y = CW'(cy);
        for (int i = 0; i < N; i++) begin
            dest_x[i*CW +: CW] = CW'(tx[i]);
            dest_y[i*CW +: CW] = CW'(ty[i]);
        end
        dest_valid = v;
        quad_hint  = h;
        start      = 1'b1;
        exp = model(v, h);
        for (int d = 0; d < 5; d++) em[d] = |exp[d*N +: N];
        @(negedge clk);
        start = 1'b0;
        chk(out_valid === 1'b1, "R1 valid pulse", 64'(out_valid), 64'd1);
        chk(dir_dests === exp, tag, 64'(dir_dests), 64'(exp));
        chk(dir_mask === em, "R9 direction mask", 64'(dir_mask), 64'(em));
        held = dir_dests;
        dest_valid = ~v;
        quad_hint  = ~h;
        cur_x      = cur_x + 1'b1;
        @(negedge clk);
        chk(out_valid === 1'b0, "R1 single cycle", 64'(out_valid), 64'd0);
        chk(dir_dests === held, "R1 result held", 64'(dir_dests), 64'(held));
    endtask

    task automatic clear();
        for (int i = 0; i < N; i++) begin tx[i] = cx; ty[i] = cy; end
    endtask

    initial begin
        #(8 * 200000);
        nbad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(out_valid === 1'b0 && dir_mask === '0 && dir_dests === '0,
            "R2 reset state", 64'(dir_dests), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(out_valid === 1'b0 && dir_dests === '0, "R2 after reset", 64'(dir_dests), 64'd0);

        cx = 3; cy = 3;
        // R3: one local destination
        clear();
        run(10'b1, 4'h0, "R3 local");
        chk(dir_dests === (50'd1 << (4*N)), "R3 local bit", 64'(dir_dests), 64'd1 << (4*N));

        // R4: four axis destinations
        clear();
        tx[0] = 5; tx[1] = 1; ty[2] = 6; ty[3] = 0;
        run(10'b1111, 4'h0, "R4 axis");
        chk(dir_mask === 5'b01111, "R4 axis mask", 64'(dir_mask), 64'b01111);

        // R5: join existing axis direction, horizontal preferred
        clear();
        tx[0] = 5; ty[1] = 6; tx[2] = 6; ty[2] = 6; tx[3] = 1; ty[3] = 5;
        run(10'b1111, 4'h0, "R5 join");
        chk(dir_dests[0*N+2] === 1'b1 && dir_dests[2*N+3] === 1'b1,
            "R5 join placement", 64'(dir_dests), 64'(model(10'b1111, 4'h0)));

        // R6: grouping with a tie between East and North
        clear();
        tx[0] = 5; ty[0] = 5; tx[1] = 1; ty[1] = 5; tx[2] = 5; ty[2] = 1;
        run(10'b111, 4'h0, "R6 group");
        chk(dir_dests[0*N+0] === 1'b1 && dir_dests[0*N+2] === 1'b1 && dir_dests[2*N+1] === 1'b1,
            "R6 group placement", 64'(dir_dests), 64'(model(10'b111, 4'h0)));

        // R7: lone quadrant destination follows hint
        clear();
        tx[0] = 1; ty[0] = 1;
        run(10'b1, 4'b1000, "R7 hint horizontal");
        chk(dir_dests === (50'd1 << (1*N)), "R7 west", 64'(dir_dests), 64'd1 << N);
        run(10'b1, 4'b0111, "R7 hint vertical");
        chk(dir_dests === (50'd1 << (3*N)), "R7 south", 64'(dir_dests), 64'd1 << (3*N));

        // R8: invalid slots are ignored
        clear();
        for (int i = 0; i < N; i++) begin tx[i] = 6; ty[i] = 3; end
        run(10'b0000000100, 4'h0, "R8 invalid ignored");
        chk(dir_dests === (50'd1 << 2), "R8 only slot 2", 64'(dir_dests), 64'd4);

        // R10: random sweep on a small grid
        for (int k = 0; k < 4000; k++) begin
            logic [N-1:0] v;
            cx = $urandom_range(0, 7);
            cy = $urandom_range(0, 7);
            for (int i = 0; i < N; i++) begin
                tx[i] = $urandom_range(0, 7);
                ty[i] = $urandom_range(0, 7);
                v[i]  = ($urandom_range(0, 7) != 0);
            end
            run(v, 4'($urandom_range(0, 15)), "R10 random");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
        $finish;
    end

endmodule